// File: doc/BRIEF.md
# Cursor Plane Register Arming Unit

This block holds the programming state of a hardware cursor plane. There are four registers: control, position, base address and partial height. Each one has a pending copy, written over a single-cycle register bus, and an active copy that scanout uses. Pending values move into the active set only after an update has been armed, and then only on the next vertical-blank pulse. Software therefore sees the whole cursor change at once, never a mix of old and new values.

An update is armed by writing the base-address register. Writing any other register while an update is armed disarms it, and a fresh base write is needed to arm it again. The one exception is turning a disabled cursor on: a control write that gives a non-zero mode while the active cursor is off arms the update by itself. The block also decodes the active registers into scanout parameters: enable, width, height, rotation, pipe gamma and colour-space-conversion enables, and signed X and Y coordinates.

Top module: `cursor_arm_regs`

## Requirements
- R1: After reset all active registers are zero. The cursor is disabled, with width, height, X, Y and base all 0, and `arm_pending` and `ph_err` are both 0.
- R2: A bus write stores `wr_data` in the pending copy chosen by `bus_addr` (0 control, 1 position, 2 base, 3 partial height). `rd_data` returns the pending copy at `bus_addr` in the same cycle, and the active outputs do not change because of the write.
- R3: A write to the base register (address 2) sets `arm_pending` from the next cycle. On the next clock with `vblank` high, all four pending copies become active together and `arm_pending` clears.
- R4: A `vblank` pulse while `arm_pending` is 0 leaves every active output unchanged.
- R5: A write to address 0, 1 or 3 clears `arm_pending`, unless it is the enabling write described in R6. The pending values then stay pending through later `vblank` pulses until another base write re-arms the update.
- R6: While the active cursor is disabled, a control write with a non-zero mode field sets `arm_pending`. While the active cursor is enabled, a control write does not arm.
- R7: Control bits [1:0] are the mode. Mode 0 is disabled, with width and height 0. Modes 1, 2 and 3 give an enabled cursor of width 64, 128 and 256.
- R8: Position bits [POS_MAG_W-1:0] hold the X magnitude and bit 15 the X sign. Bits [16+POS_MAG_W-1:16] hold the Y magnitude and bit 31 the Y sign. A set sign bit makes the coordinate the negative of its magnitude.
- R9: Partial-height bit 31 is the enable and bits [7:0] hold height minus 1. When it is enabled, the cursor is not rotated and the height lies from 8 to the width, `cur_height` takes that height. Otherwise `cur_height` equals `cur_width`.
- R10: Control bit 4 selects 180-degree rotation and appears on `cur_rot`. With rotation the height always equals the width.
- R11: When an enabled, unrotated cursor has partial height turned on and the height is below 8 or above the width, the height is clamped to the width. `ph_err` rises within one clock and stays set until reset.
- R12: Control bits 8 and 9 are passed to `cur_gamma` and `cur_csc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select for both read and write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Pending copy of the selected register |
| vblank | input | 1 | Vertical-blank pulse |
| cur_en | output | 1 | Active cursor enabled |
| cur_width | output | 9 | Active cursor width in pixels |
| cur_height | output | 9 | Active cursor height in lines |
| cur_rot | output | 1 | 180-degree rotation |
| cur_gamma | output | 1 | Pipe gamma enable |
| cur_csc | output | 1 | Pipe colour-space-conversion enable |
| cur_x | output | POS_MAG_W+1 | Signed X coordinate |
| cur_y | output | POS_MAG_W+1 | Signed Y coordinate |
| cur_base | output | 32 | Active base address |
| arm_pending | output | 1 | An update is armed and waiting for vertical blank |
| ph_err | output | 1 | Sticky flag for an out-of-range partial height |

## Verification
A wrong arm flag is visible on `arm_pending` one cycle after the write that set or cleared it. It is also visible on the active outputs at the next `vblank`: a transfer that happens when it should not, or is missing when it should happen, changes `cur_base` and the decoded geometry on that edge. A wrong width, height, clamp or sign decode shows on the outputs as soon as the active copy is loaded, and a missing or lost error flag shows one cycle later.

// File: rtl/cursor_arm_pkg.sv
package cursor_arm_pkg;
    localparam int REG_W      = 32;
    localparam int NUM_REGS   = 4;
    localparam int ADDR_W     = $clog2(NUM_REGS);
    localparam int SIZE_W     = 9;
    localparam int PH_FIELD_W = 8;
    localparam int PH_MIN     = 8;

    localparam logic [ADDR_W-1:0] A_CTL  = 2'd0;
    localparam logic [ADDR_W-1:0] A_POS  = 2'd1;
    localparam logic [ADDR_W-1:0] A_BASE = 2'd2;
    localparam logic [ADDR_W-1:0] A_PH   = 2'd3;

    localparam int CTL_ROT_BIT   = 4;
    localparam int CTL_GAMMA_BIT = 8;
    localparam int CTL_CSC_BIT   = 9;
    localparam int POS_X_SIGN    = 15;
    localparam int POS_Y_LSB     = 16;
    localparam int POS_Y_SIGN    = 31;
    localparam int PH_EN_BIT     = 31;

    typedef logic [NUM_REGS-1:0][REG_W-1:0] reg_set_t;
endpackage

// File: rtl/cursor_arm_bank.sv
module cursor_arm_bank
    import cursor_arm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              vblank,
    output reg_set_t          pend_o,
    output reg_set_t          act_o,
    output logic              arm_o
);
    typedef struct packed {
        reg_set_t pend;
        reg_set_t act;
        logic     arm;
    } bank_t;

    bank_t state_d, state_q;
    logic [NUM_REGS-1:0] sel;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_REGS; gi++) begin : g_sel
            assign sel[gi] = wr_en && (addr == ADDR_W'(gi));
        end
    endgenerate

    logic act_off, wr_turns_on;
    assign act_off     = (state_q.act[A_CTL][1:0] == 2'd0);
    assign wr_turns_on = act_off && (wr_data[1:0] != 2'd0);

    always_comb begin
        state_d = state_q;
        if (vblank && state_q.arm) begin
            state_d.act = state_q.pend;
            state_d.arm = 1'b0;
        end
        for (int i = 0; i < NUM_REGS; i++) begin
            if (sel[i]) state_d.pend[i] = wr_data;
        end
        if (wr_en) begin
            if (addr == A_BASE)                     state_d.arm = 1'b1;
            else if (addr == A_CTL && wr_turns_on)  state_d.arm = 1'b1;
            else                                    state_d.arm = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign pend_o = state_q.pend;
    assign act_o  = state_q.act;
    assign arm_o  = state_q.arm;
endmodule

// File: rtl/cursor_geom_decode.sv
module cursor_geom_decode
    import cursor_arm_pkg::*;
#(
    parameter int POS_MAG_W = 12
) (
    input  logic [REG_W-1:0]        ctl,
    input  logic [REG_W-1:0]        pos,
    input  logic [REG_W-1:0]        ph,
    output logic                    en,
    output logic [SIZE_W-1:0]       width,
    output logic [SIZE_W-1:0]       height,
    output logic                    rot,
    output logic                    gamma,
    output logic                    csc,
    output logic signed [POS_MAG_W:0] x,
    output logic signed [POS_MAG_W:0] y,
    output logic                    ph_bad
);
    localparam logic [SIZE_W-1:0] UNIT = SIZE_W'(32);

    logic [1:0]           mode;
    logic [SIZE_W-1:0]    ph_h;
    logic                 use_ph;
    logic [POS_MAG_W-1:0] xm, ym;
    logic                 unused_bits;

    assign mode  = ctl[1:0];
    assign en    = (mode != 2'd0);
    assign rot   = ctl[CTL_ROT_BIT];
    assign gamma = ctl[CTL_GAMMA_BIT];
    assign csc   = ctl[CTL_CSC_BIT];

    always_comb begin
        width = '0;
        if (en) width = UNIT << mode;
    end

    assign ph_h   = SIZE_W'(ph[PH_FIELD_W-1:0]) + SIZE_W'(1);
    assign use_ph = en && ph[PH_EN_BIT] && !rot;
    assign ph_bad = use_ph && ((ph_h < SIZE_W'(PH_MIN)) || (ph_h > width));

    always_comb begin
        if (!en)                   height = '0;
        else if (use_ph && !ph_bad) height = ph_h;
        else                       height = width;
    end

    assign xm = pos[POS_MAG_W-1:0];
    assign ym = pos[POS_Y_LSB +: POS_MAG_W];
    assign x  = pos[POS_X_SIGN] ? -$signed({1'b0, xm}) : $signed({1'b0, xm});
    assign y  = pos[POS_Y_SIGN] ? -$signed({1'b0, ym}) : $signed({1'b0, ym});

    assign unused_bits = ^{ctl, pos, ph};
endmodule

// File: rtl/cursor_arm_regs.sv
module cursor_arm_regs
    import cursor_arm_pkg::*;
#(
    parameter int POS_MAG_W = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [1:0]                bus_addr,
    input  logic [31:0]               wr_data,
    output logic [31:0]               rd_data,
    input  logic                      vblank,
    output logic                      cur_en,
    output logic [8:0]                cur_width,
    output logic [8:0]                cur_height,
    output logic                      cur_rot,
    output logic                      cur_gamma,
    output logic                      cur_csc,
    output logic signed [POS_MAG_W:0] cur_x,
    output logic signed [POS_MAG_W:0] cur_y,
    output logic [31:0]               cur_base,
    output logic                      arm_pending,
    output logic                      ph_err
);
    typedef struct packed {
        logic err;
    } flag_t;

    reg_set_t pend, act;
    logic     ph_bad;
    flag_t    flag_d, flag_q;

    cursor_arm_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (bus_addr),
        .wr_data (wr_data),
        .vblank  (vblank),
        .pend_o  (pend),
        .act_o   (act),
        .arm_o   (arm_pending)
    );

    cursor_geom_decode #(.POS_MAG_W(POS_MAG_W)) u_dec (
        .ctl    (act[A_CTL]),
        .pos    (act[A_POS]),
        .ph     (act[A_PH]),
        .en     (cur_en),
        .width  (cur_width),
        .height (cur_height),
        .rot    (cur_rot),
        .gamma  (cur_gamma),
        .csc    (cur_csc),
        .x      (cur_x),
        .y      (cur_y),
        .ph_bad (ph_bad)
    );

    always_comb begin
        flag_d     = flag_q;
        flag_d.err = flag_q.err | ph_bad;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign ph_err   = flag_q.err;
    assign rd_data  = pend[bus_addr];
    assign cur_base = act[A_BASE];
endmodule

// File: rtl/cursor_arm_regs_chk.sv
module cursor_arm_regs_chk
    import cursor_arm_pkg::*;
#(
    parameter int POS_MAG_W = 12
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      wr_en,
    input logic [1:0]                bus_addr,
    input logic [31:0]               wr_data,
    input logic [31:0]               rd_data,
    input logic                      vblank,
    input logic                      cur_en,
    input logic [8:0]                cur_width,
    input logic [8:0]                cur_height,
    input logic                      cur_rot,
    input logic                      cur_gamma,
    input logic                      cur_csc,
    input logic signed [POS_MAG_W:0] cur_x,
    input logic signed [POS_MAG_W:0] cur_y,
    input logic [31:0]               cur_base,
    input logic                      arm_pending,
    input logic                      ph_err
);
    logic en_write;
    assign en_write = wr_en && bus_addr == A_CTL && !cur_en && wr_data[1:0] != 2'd0;

    p_base_arms_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && bus_addr == A_BASE |=> arm_pending);

    p_vblank_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        arm_pending && vblank && !wr_en |=> !arm_pending);

    p_no_vblank_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !vblank |=> $stable(cur_base) && $stable(cur_width) && $stable(cur_x));

    p_idle_vblank_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_pending |=> $stable(cur_base) && $stable(cur_height));

    p_cancel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && bus_addr != A_BASE && !en_write |=> !arm_pending);

    p_enable_arms_r6: assert property (@(posedge clk) disable iff (!rst_n)
        en_write |=> arm_pending);

    p_height_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cur_en |-> cur_height <= cur_width && cur_height >= 9'(PH_MIN));

    p_rot_square_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cur_en && cur_rot |-> cur_height == cur_width);

    p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ph_err |=> ph_err);

    p_off_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_en |-> cur_width == 9'd0 && cur_height == 9'd0);
endmodule

bind cursor_arm_regs cursor_arm_regs_chk #(.POS_MAG_W(POS_MAG_W)) u_chk (.*);

// File: tb/sim_cursor_arm_regs.sv
module sim_cursor_arm_regs;
    localparam int MW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [31:0] wr_data = '0;
    logic vblank = 1'b0;
    logic [31:0] rd_data;
    logic cur_en, cur_rot, cur_gamma, cur_csc, arm_pending, ph_err;
    logic [8:0] cur_width, cur_height;
    logic signed [MW:0] cur_x, cur_y;
    logic [31:0] cur_base;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit exp_err = 1'b0;

    always #2.5 clk = ~clk;

    cursor_arm_regs #(.POS_MAG_W(MW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .bus_addr(bus_addr),
        .wr_data(wr_data), .rd_data(rd_data), .vblank(vblank),
        .cur_en(cur_en), .cur_width(cur_width), .cur_height(cur_height),
        .cur_rot(cur_rot), .cur_gamma(cur_gamma), .cur_csc(cur_csc),
        .cur_x(cur_x), .cur_y(cur_y), .cur_base(cur_base),
        .arm_pending(arm_pending), .ph_err(ph_err)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; bus_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic vb();
        @(negedge clk);
        vblank = 1'b1;
        @(negedge clk);
        vblank = 1'b0;
    endtask

    function automatic int exp_w(input int mode);
        return (mode == 0) ? 0 : (32 << mode);
    endfunction

    function automatic bit ph_bad(input int mode, input int rot, input int en, input int f);
        int w = exp_w(mode);
        int h = f + 1;
        return (w != 0) && (rot == 0) && (en != 0) && (h < 8 || h > w);
    endfunction

    function automatic int exp_h(input int mode, input int rot, input int en, input int f);
        int w = exp_w(mode);
        if (w == 0 || rot != 0 || en == 0 || ph_bad(mode, rot, en, f)) return w;
        return f + 1;
    endfunction

    function automatic logic [31:0] ctl_word(input int mode, input int rot, input int g, input int c);
        return 32'(mode) | (32'(rot) << 4) | (32'(g) << 8) | (32'(c) << 9);
    endfunction

    function automatic logic [31:0] pos_word(input int xs, input int xm, input int ys, input int ym);
        return 32'(xm) | (32'(xs) << 15) | (32'(ym) << 16) | (32'(ys) << 31);
    endfunction

    task automatic load(input logic [31:0] c, input logic [31:0] p, input logic [31:0] h, input logic [31:0] b);
        wr(2'd0, c);
        wr(2'd1, p);
        wr(2'd3, h);
        wr(2'd2, b);
        chk("R3 armed after base write", arm_pending, 1);
        vb();
        chk("R3 arm cleared by vblank", arm_pending, 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 cur_en", cur_en, 0);
        chk("R1 width", cur_width, 0);
        chk("R1 height", cur_height, 0);
        chk("R1 base", cur_base, 0);
        chk("R1 x", cur_x, 0);
        chk("R1 arm", arm_pending, 0);
        chk("R1 err", ph_err, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 pending readback, R6 enable-arms
        wr(2'd0, ctl_word(2, 0, 0, 0));
        bus_addr = 2'd0; #1;
        chk("R2 rd ctl", rd_data, ctl_word(2, 0, 0, 0));
        chk("R2 active untouched", cur_en, 0);
        chk("R6 enabling write arms", arm_pending, 1);
        wr(2'd1, pos_word(0, 5, 0, 6));
        chk("R5 pos write cancels", arm_pending, 0);
        bus_addr = 2'd1; #1;
        chk("R2 rd pos", rd_data, pos_word(0, 5, 0, 6));
        vb(); @(negedge clk);
        chk("R5 cancelled: no transfer", cur_en, 0);
        wr(2'd0, ctl_word(2, 0, 0, 0));
        chk("R6 re-arm by enabling write", arm_pending, 1);
        vb(); @(negedge clk);
        chk("R6 enabled without base write", cur_en, 1);
        chk("R7 width mode2", cur_width, 128);
        chk("R8 x after enable", cur_x, 5);

        // R9 valid partial height, no error
        load(ctl_word(1, 0, 0, 0), 0, 32'h8000_001F, 32'h1111_0000);
        chk("R9 partial height 32", cur_height, 32);
        chk("R11 no err for valid height", ph_err, 0);
        chk("R3 base latched", cur_base, 32'h1111_0000);

        // R4 vblank without arm; R6 ctl write while enabled does not arm
        wr(2'd0, ctl_word(3, 0, 0, 0));
        chk("R6 no arm while enabled", arm_pending, 0);
        vb(); @(negedge clk);
        chk("R4 width unchanged", cur_width, 64);
        chk("R4 base unchanged", cur_base, 32'h1111_0000);

        // R5 cancel by ph write, then re-arm
        wr(2'd2, 32'h2222_0000);
        wr(2'd3, 32'h8000_0027);
        chk("R5 ph write cancels", arm_pending, 0);
        vb(); @(negedge clk);
        chk("R5 base held", cur_base, 32'h1111_0000);
        wr(2'd2, 32'h2222_0000);
        vb(); @(negedge clk);
        chk("R3 re-armed base", cur_base, 32'h2222_0000);
        chk("R3 all latch together width", cur_width, 256);
        chk("R9 height 40", cur_height, 40);

        // Geometry sweep: R7 R9 R10 R11 R12
        for (int mode = 0; mode < 4; mode++)
            for (int rot = 0; rot < 2; rot++)
                for (int en = 0; en < 2; en++)
                    for (int k = 0; k < 9; k++) begin
                        int fl[9] = '{0, 6, 7, 50, 63, 64, 127, 200, 255};
                        int f = fl[k];
                        int g = f & 1;
                        int c = rot ^ en;
                        logic [31:0] b = 32'hA000_0000 | 32'(mode * 64 + rot * 32 + en * 16 + k);
                        load(ctl_word(mode, rot, g, c), 0, (32'(en) << 31) | 32'(f), b);
                        if (ph_bad(mode, rot, en, f)) exp_err = 1'b1;
                        @(negedge clk);
                        chk("R7 enable", cur_en, mode != 0);
                        chk("R7 width", cur_width, exp_w(mode));
                        chk("R9 R10 R11 height", cur_height, exp_h(mode, rot, en, f));
                        chk("R10 rot", cur_rot, rot);
                        chk("R12 gamma", cur_gamma, g);
                        chk("R12 csc", cur_csc, c);
                        chk("R11 sticky err", ph_err, exp_err);
                        chk("R3 base", cur_base, b);
                    end

        // Position sweep: R8
        for (int xs = 0; xs < 2; xs++)
            for (int xi = 0; xi < 4; xi++)
                for (int ys = 0; ys < 2; ys++)
                    for (int yi = 0; yi < 4; yi++) begin
                        int ml[4] = '{0, 1, 100, 4095};
                        int xm = ml[xi];
                        int ym = ml[3 - yi];
                        load(ctl_word(2, 0, 0, 0), pos_word(xs, xm, ys, ym), 0, 32'h5000_0000);
                        chk("R8 x", cur_x, xs ? -xm : xm);
                        chk("R8 y", cur_y, ys ? -ym : ym);
                    end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule